// File: doc/BRIEF.md
# Load/Store Unit with Offset and Indexed Addressing

This block carries out byte, halfword and word loads and stores against a 32-bit little-endian data memory that has one write enable per byte lane. For each request it forms an effective address either as a base register plus a zero-extended 12-bit unsigned offset, or as a base register plus an index register. In the request cycle it drives the memory address, the lane enables and the store data spread across the lanes. One cycle later it returns a response. For a load, the response carries the fetched value shifted down to bit 0 and zero-extended.

An access is misaligned when it is a halfword at an odd address, or a word whose address is not a multiple of four. A misaligned access never reaches the memory. Its response instead carries an error flag. Opcodes outside the load/store range are ignored. The memory is expected to capture writes and present read data on the clock edge that ends the request cycle.

Top module: `lsu_core`

## Requirements
- R1: Opcodes 17 to 28 are accepted. Taking rel = opcode - 17, the addressing mode is indexed when rel is odd and offset when rel is even. rel/2 selects the operation: 0 is a byte load, 1 a halfword load, 2 a word load, 3 a byte store, 4 a halfword store and 5 a word store. Any other opcode, and any cycle with req_valid_i low, produces no memory enable and no response.
- R2: In offset mode, mem_addr_o equals base_i plus offset_i zero-extended to 32 bits, modulo 2^32.
- R3: In indexed mode, mem_addr_o equals base_i plus index_i, modulo 2^32.
- R4: An aligned access raises mem_we_o for a store or mem_re_o for a load, never both. mem_be_o is set by the access size and the address. A byte access gives bit addr[1:0]. A halfword access gives 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. A word access gives 4'b1111. Without an access, mem_be_o is 0.
- R5: Store data appears on every lane. A byte store drives store_data_i[7:0] to all four bytes. A halfword store drives store_data_i[15:0] to both halves. A word store drives store_data_i unchanged.
- R6: In the cycle after a load request, rsp_data_o holds the addressed bytes in little-endian order (the lowest address is the least significant byte), zero-extended to 32 bits.
- R7: A halfword access at an odd address, or a word access with addr[1:0] not 0, raises neither memory enable. In the next cycle misalign_o is 1 along with rsp_valid_o, and rsp_data_o is 0.
- R8: rsp_valid_o is 1 exactly in the cycle after each accepted request, for loads and stores alike. rsp_data_o is 0 for store responses.
- R9: While reset is held, rsp_valid_o, misalign_o and rsp_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request present this cycle |
| opcode_i | input | 6 | Operation and addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value (indexed mode) |
| offset_i | input | 12 | Unsigned offset (offset mode) |
| store_data_i | input | 32 | Target register value for stores |
| mem_addr_o | output | 32 | Effective byte address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_rdata_i | input | 32 | Memory read word, valid the cycle after mem_re_o |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_data_o | output | 32 | Aligned, zero-extended load result |
| misalign_o | output | 1 | Previous request was misaligned and was suppressed |

## Verification
A load response and a new store request can fall in the same cycle. In that cycle the unit shifts the word it has just read while it also drives write enables and lane data for a store to the same word. The bench provokes this with a word load immediately followed by a word store to the same address. It requires the returned load value to be the old contents while the store strobe is high, and then reads the word back to confirm the new data landed. Sweeps over every byte address, for all sizes and both modes, cover the alignment and lane cases around it.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_B = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      store;
    logic      idx_mode;
    acc_size_e size;
  } acc_ctl_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OPC_W    = 6,
  parameter int OPC_BASE = 17
) (
  input  logic [OPC_W-1:0] opc,
  output acc_ctl_t         ctl
);
  localparam logic [OPC_W-1:0] FIRST = OPC_W'(OPC_BASE);
  localparam logic [OPC_W-1:0] SPAN  = OPC_W'(12);

  logic [OPC_W-1:0] rel;
  logic [2:0]       op_sel;

  always_comb begin
    rel          = opc - FIRST;
    op_sel       = rel[3:1];
    ctl.legal    = (rel < SPAN);
    ctl.idx_mode = rel[0];
    ctl.store    = (op_sel >= 3'd3);
    case (op_sel)
      3'd0, 3'd3: ctl.size = SZ_BYTE;
      3'd1, 3'd4: ctl.size = SZ_HALF;
      default:    ctl.size = SZ_WORD;
    endcase
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [OFF_W-1:0]  offset,
  input  logic              idx_mode,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic [LANES-1:0]  be,
  output logic              misal
);
  logic [ADDR_W-1:0] addend;
  logic [LANE_B-1:0] lane;

  always_comb begin
    addend = idx_mode ? index : {{(ADDR_W-OFF_W){1'b0}}, offset};
    ea     = base + addend;
    lane   = ea[LANE_B-1:0];
    case (size)
      SZ_HALF: misal = lane[0];
      SZ_WORD: misal = |lane;
      default: misal = 1'b0;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_B-1:0] GL = LANE_B'(g);
    always_comb begin
      case (size)
        SZ_BYTE: be[g] = (GL == lane);
        SZ_HALF: be[g] = (GL[LANE_B-1:1] == lane[LANE_B-1:1]);
        default: be[g] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lsu_wdata.sv
module lsu_wdata
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_rep
    always_comb begin
      case (size)
        SZ_BYTE: dout[8*g +: 8] = din[7:0];
        SZ_HALF: dout[8*g +: 8] = din[8*(g % 2) +: 8];
        default: dout[8*g +: 8] = din[8*g +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_ldalign.sv
module lsu_ldalign
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_B-1:0] lane,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    case (size)
      SZ_BYTE: dout = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      SZ_HALF: dout = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: dout = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int OPC_W    = 6,
  parameter int OPC_BASE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              misalign_o
);
  // reset release synchroniser
  logic rst_s0, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  acc_ctl_t          ctl;
  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  be;
  logic              misal;

  lsu_decode #(.OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) u_dec (
    .opc (opcode_i),
    .ctl (ctl)
  );

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base     (base_i),
    .index    (index_i),
    .offset   (offset_i),
    .idx_mode (ctl.idx_mode),
    .size     (ctl.size),
    .ea       (ea),
    .be       (be),
    .misal    (misal)
  );

  lsu_wdata u_wd (
    .din  (store_data_i),
    .size (ctl.size),
    .dout (mem_wdata_o)
  );

  // request-cycle control
  logic go, access;
  always_comb begin
    go         = req_valid_i && ctl.legal;
    access     = go && !misal;
    mem_addr_o = ea;
    mem_we_o   = access && ctl.store;
    mem_re_o   = access && !ctl.store;
    mem_be_o   = access ? be : '0;
  end

  // next-state for the response stage
  logic              rsp_v_d, mis_d, ld_d, cap_en;
  logic [LANE_B-1:0] lane_d;
  acc_size_e         size_d;
  logic              rsp_v_q, mis_q, ld_q;
  logic [LANE_B-1:0] lane_q;
  acc_size_e         size_q;

  always_comb begin
    rsp_v_d = go;
    mis_d   = go && misal;
    ld_d    = access && !ctl.store;
    cap_en  = go;
    lane_d  = ea[LANE_B-1:0];
    size_d  = ctl.size;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_v_q <= 1'b0;
      mis_q   <= 1'b0;
      ld_q    <= 1'b0;
      lane_q  <= '0;
      size_q  <= SZ_BYTE;
    end else begin
      rsp_v_q <= rsp_v_d;
      mis_q   <= mis_d;
      ld_q    <= ld_d;
      if (cap_en) begin
        lane_q <= lane_d;
        size_q <= size_d;
      end
    end
  end

  logic [DATA_W-1:0] aligned;
  lsu_ldalign u_la (
    .rdata (mem_rdata_i),
    .lane  (lane_q),
    .size  (size_q),
    .dout  (aligned)
  );

  always_comb begin
    rsp_valid_o = rsp_v_q;
    misalign_o  = mis_q;
    rsp_data_o  = ld_q ? aligned : '0;
  end
endmodule

// File: rtl/lsu_checks.sv
module lsu_checks #(
  parameter int ADDR_W   = 32,
  parameter int OPC_W    = 6,
  parameter int OPC_BASE = 17
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              req_valid_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_data_o,
  input logic              misalign_o
);
  localparam logic [OPC_W-1:0] LO = OPC_W'(OPC_BASE);
  localparam logic [OPC_W-1:0] HI = OPC_W'(OPC_BASE + 11);

  logic accepted;
  assign accepted = req_valid_i && (opcode_i >= LO) && (opcode_i <= HI);

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    accepted |=> rsp_valid_o);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !accepted |=> !rsp_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid_i |-> (!mem_we_o && !mem_re_o));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_we_o |-> !mem_re_o);

  assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_we_o || mem_re_o) |->
      ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));

  assert_half_aligned_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ((mem_we_o || mem_re_o) && $countones(mem_be_o) == 2) |-> !mem_addr_o[0]);

  assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ((mem_we_o || mem_re_o) && $countones(mem_be_o) == 4) |-> (mem_addr_o[1:0] == 2'b00));

  assert_misal_rsp_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    misalign_o |-> (rsp_valid_o && rsp_data_o == 32'd0));
endmodule

bind lsu_core lsu_checks #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .req_valid_i (req_valid_i),
  .opcode_i    (opcode_i),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .misalign_o  (misalign_o)
);

// File: tb/sim_lsu_core.sv
`timescale 1ns/1ps
module sim_lsu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [5:0]  opcode_i;
  logic [31:0] base_i, index_i, store_data_i;
  logic [11:0] offset_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rsp_data_o;
  logic [3:0]  mem_be_o;
  logic        mem_we_o, mem_re_o, rsp_valid_o, misalign_o;

  always #5 clk = ~clk;

  lsu_core u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .opcode_i(opcode_i),
    .base_i(base_i), .index_i(index_i), .offset_i(offset_i), .store_data_i(store_data_i),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o), .misalign_o(misalign_o)
  );

  // behavioural 64-byte memory
  logic [31:0] mem [16];
  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[5:2]];
    if (mem_we_o)
      for (int l = 0; l < 4; l++)
        if (mem_be_o[l]) mem[mem_addr_o[5:2]][8*l +: 8] <= mem_wdata_o[8*l +: 8];
  end

  logic [7:0] model [64];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request and check both its cycles; leaves req_valid_i low
  task automatic issue(input logic [5:0] op, input logic [31:0] b, input logic [31:0] ix,
                       input logic [11:0] of, input logic [31:0] sd);
    int rel, sz, a;
    logic legal, st, im, mis, acc;
    logic [31:0] ea, edata, ewd;
    logic [3:0] ebe;
    rel   = int'(op) - 17;
    legal = (rel >= 0) && (rel < 12);
    im    = legal && (rel % 2 == 1);
    st    = legal && ((rel / 2) >= 3);
    sz    = legal ? (rel / 2) % 3 : 0;
    ea    = im ? b + ix : b + {20'd0, of};
    mis   = (sz == 1 && ea[0]) || (sz == 2 && ea[1:0] != 2'b00);
    acc   = legal && !mis;
    a     = int'(ea[5:0]);
    ebe   = (sz == 2) ? 4'hF : (sz == 1) ? (ea[1] ? 4'hC : 4'h3) : (4'h1 << ea[1:0]);
    ewd   = (sz == 0) ? {4{sd[7:0]}} : (sz == 1) ? {2{sd[15:0]}} : sd;
    edata = 32'd0;
    if (acc && !st) begin
      edata[7:0] = model[a];
      if (sz >= 1) edata[15:8] = model[a+1];
      if (sz == 2) begin edata[23:16] = model[a+2]; edata[31:24] = model[a+3]; end
    end
    req_valid_i = 1'b1; opcode_i = op; base_i = b; index_i = ix; offset_i = of; store_data_i = sd;
    #1;
    if (legal) chk(im ? "R3 indexed address" : "R2 offset address", mem_addr_o, ea);
    if (!legal) chk("R1 illegal opcode no enable", {30'd0, mem_we_o, mem_re_o}, 32'd0);
    else if (mis) chk("R7 misaligned no enable", {30'd0, mem_we_o, mem_re_o}, 32'd0);
    else begin
      chk("R4 strobes", {30'd0, mem_we_o, mem_re_o}, {30'd0, st, !st});
      chk("R4 lane enables", {28'd0, mem_be_o}, {28'd0, ebe});
      if (st) chk("R5 replicated write data", mem_wdata_o, ewd);
    end
    if (acc && st) begin
      model[a] = sd[7:0];
      if (sz >= 1) model[a+1] = sd[15:8];
      if (sz == 2) begin model[a+2] = sd[23:16]; model[a+3] = sd[31:24]; end
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    #1;
    chk(legal ? "R8 response valid" : "R1 no response", {31'd0, rsp_valid_o}, {31'd0, legal});
    chk("R7 misalign flag", {31'd0, misalign_o}, {31'd0, legal && mis});
    chk((acc && !st) ? "R6 load data" : "R8 response data zero", rsp_data_o, edata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid_i = 1'b0; opcode_i = '0; base_i = '0; index_i = '0;
    offset_i = '0; store_data_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    chk("R9 reset misalign", {31'd0, misalign_o}, 32'd0);
    chk("R9 reset data", rsp_data_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // fill memory with word stores (offset mode, opcode 27)
    for (int w = 0; w < 16; w++)
      issue(6'd27, 32'h2000_0000, 32'd0, 12'(4*w), (w * 32'h0101_0101) ^ 32'hA5C3_0F96);

    // unsigned offset: 1 + 0xFFF = 0x1000, not 0 (R2)
    issue(6'd21, 32'h0000_0001, 32'd0, 12'hFFF, 32'd0);

    // every non-load/store opcode (R1)
    for (int op = 0; op < 64; op++)
      if (op < 17 || op > 28) issue(6'(op), 32'h0000_0010, 32'h4, 12'h8, 32'hFFFF_FFFF);

    // loads: all sizes, both modes, every byte address (R2 R3 R4 R6 R7)
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 3; s++) begin
        issue(6'(17 + 2*s), 32'h1230_0000, 32'd0, 12'(a + 64 * (a % 7)), 32'd0);
        issue(6'(18 + 2*s), 32'h8000_0000 + 32'(a * 3), 32'h8000_0000 - 32'(a * 2), 12'd0, 32'd0);
      end

    // sub-word and misaligned stores (R4 R5 R7)
    for (int a = 0; a < 64; a++) begin
      issue(6'd23, 32'h0000_0040, 32'd0, 12'(a), 32'hC0DE_0000 | 32'(a * 37));
      if (a % 3 == 0) issue(6'd28, 32'hFFFF_FF00 + 32'(a), 32'h100, 12'd0, 32'h5EED_0000 + 32'(a));
    end
    for (int a = 0; a < 64; a++)
      issue(6'd26, 32'hFFFF_FF00 + 32'(a), 32'h100, 12'd0, 32'h7700_0000 | 32'(a * 521));

    // read back every word (R6)
    for (int w = 0; w < 16; w++) issue(6'd22, 32'(4*w), 32'd0, 12'd0, 32'd0);

    // load response and store request in the same cycle, same word (R6 R8)
    begin
      logic [31:0] oldw;
      oldw = {model[23], model[22], model[21], model[20]};
      req_valid_i = 1'b1; opcode_i = 6'd21; base_i = 32'd20; offset_i = 12'd0;
      @(negedge clk);
      opcode_i = 6'd27; store_data_i = 32'h1357_9BDF;
      #1;
      chk("R6 load data beside store", rsp_data_o, oldw);
      chk("R8 load response beside store", {31'd0, rsp_valid_o}, 32'd1);
      chk("R4 store strobe beside response", {31'd0, mem_we_o}, 32'd1);
      model[20] = 8'hDF; model[21] = 8'h9B; model[22] = 8'h57; model[23] = 8'h13;
      @(negedge clk);
      req_valid_i = 1'b0;
      #1;
      chk("R8 store response", {31'd0, rsp_valid_o}, 32'd1);
      chk("R8 store response data", rsp_data_o, 32'd0);
      @(negedge clk);
      issue(6'd22, 32'd16, 32'd4, 12'd0, 32'd0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule